// File: doc/BRIEF.md
# Bit-Sliced Reconfigurable Truth-Table Function Unit

This block evaluates a user-defined word operation in one combinational pass. It is a single row of identical 1-bit slices. Each slice looks up its result bit and an outgoing carry in two truth tables of its own, each 64 entries deep. A chain of dependent integer operations can be collapsed offline into per-bit tables. The unit then produces the combined result without stepping through the operations one by one. Carries ripple from each slice into the next higher one, so operations such as addition fit in the same row.

A write port loads one table at a time. A write names the slice, picks the result table or the carry table, and supplies the 64 table bits with a count of active lookup inputs. The only registers are these tables and counts. Evaluation from the operand words, the carry-in and a small auxiliary input word to the result and carry-out involves no clock.

Top module: `lut_slice_fu`

## Requirements
- R1: While reset is asserted, and after its release until the first table write, every table and count is zero, so `fu_res` and `carry_out` read 0 for any operands.
- R2: A write with `cfg_we` high updates the selected table on the next rising clock edge and not before. Only the slice named by `cfg_idx` and the table named by `cfg_sel` change: 0 selects the result table, 1 the carry table.
- R3: The 6-bit lookup index of slice i has `op_a[i]` at bit 0, `op_b[i]` at bit 1 and the slice's incoming carry at bit 2. `aux_in[0]`, `aux_in[1]` and `aux_in[2]` sit at bits 3 to 5.
- R4: Each table's stored count c masks its index: index bits at positions c and above are forced to 0. A count above 6 acts as 6, and a count of 0 always reads entry 0.
- R5: Slice 0 takes `carry_in` as its incoming carry, and slice i>0 takes the carry table output of slice i-1. `carry_out` is the carry table output of the top slice.
- R6: `fu_res` and `carry_out` follow changes of `op_a`, `op_b`, `carry_in` and `aux_in` without any clock edge.
- R7: A write whose `cfg_idx` is WIDTH or more changes no table.
- R8: With the result table 0x96 and the carry table 0xE8, both with count 3, loaded in every slice, {`carry_out`,`fu_res`} equals `op_a + op_b + carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table writes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Slice addressed by the write |
| cfg_sel | input | 1 | 0 result table, 1 carry table |
| cfg_table | input | 64 | Truth table contents, entry k at bit k |
| cfg_count | input | 3 | Number of active index bits |
| op_a | input | WIDTH | Operand word A |
| op_b | input | WIDTH | Operand word B |
| carry_in | input | 1 | Carry into slice 0 |
| aux_in | input | 3 | Shared extra lookup inputs |
| fu_res | output | WIDTH | Result word |
| carry_out | output | 1 | Carry from the top slice |

## Verification
A corrupted table entry or count shows up only when the operands select that entry. Until then the ports look healthy. After that it appears in the same cycle, in the affected result bit or, through the ripple, in every higher bit and `carry_out`. A write that lands in the wrong slice or table, or too early, is seen in the first evaluation after the edge. The checks therefore sweep operands over the full index space of each loaded function. They also drive the mask and auxiliary index bits separately.

// File: rtl/lut_fu_pkg.sv
package lut_fu_pkg;
  localparam int LUT_IN = 6;
  localparam int TBL_SZ = 1 << LUT_IN;
  localparam int CNT_W  = $clog2(LUT_IN + 1);
  localparam int OPD_IN = 3;
  localparam int AUX_W  = LUT_IN - OPD_IN;

  typedef struct packed {
    logic [TBL_SZ-1:0] tbl;
    logic [CNT_W-1:0]  cnt;
  } lut_cfg_t;
endpackage

// File: rtl/lut_cfg_bank.sv
module lut_cfg_bank
  import lut_fu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX_W = $clog2(WIDTH) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    sel,
  input  logic [TBL_SZ-1:0]       tbl,
  input  logic [CNT_W-1:0]        cnt,
  output lut_cfg_t [WIDTH-1:0]    res_cfg,
  output lut_cfg_t [WIDTH-1:0]    car_cfg
);
  lut_cfg_t payload;
  assign payload = '{tbl: tbl, cnt: cnt};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bank
    logic     hit, res_en, car_en;
    lut_cfg_t res_nxt, car_nxt, res_q, car_q;

    always_comb begin
      hit     = we && (idx == IDX_W'(i));
      res_en  = hit && !sel;
      car_en  = hit && sel;
      res_nxt = payload;
      car_nxt = payload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        car_q <= '0;
      end else begin
        if (res_en) res_q <= res_nxt;
        if (car_en) car_q <= car_nxt;
      end
    end

    assign res_cfg[i] = res_q;
    assign car_cfg[i] = car_q;
  end
endmodule

// File: rtl/lut_eval.sv
module lut_eval
  import lut_fu_pkg::*;
(
  input  lut_cfg_t          cfg,
  input  logic [LUT_IN-1:0] raw_idx,
  output logic              bit_out
);
  logic [CNT_W-1:0]  act_cnt;
  logic [LUT_IN-1:0] keep;
  logic [LUT_IN-1:0] idx;

  always_comb begin
    act_cnt = (cfg.cnt > CNT_W'(LUT_IN)) ? CNT_W'(LUT_IN) : cfg.cnt;
    for (int k = 0; k < LUT_IN; k++) begin
      keep[k] = (CNT_W'(k) < act_cnt);
    end
    idx     = raw_idx & keep;
    bit_out = cfg.tbl[idx];
  end
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_fu_pkg::*;
(
  input  logic             a_bit,
  input  logic             b_bit,
  input  logic             c_in,
  input  logic [AUX_W-1:0] aux,
  input  lut_cfg_t         res_cfg,
  input  lut_cfg_t         car_cfg,
  output logic             r_bit,
  output logic             c_out
);
  logic [LUT_IN-1:0] raw_idx;
  assign raw_idx = {aux, c_in, b_bit, a_bit};

  lut_eval u_res (.cfg(res_cfg), .raw_idx(raw_idx), .bit_out(r_bit));
  lut_eval u_car (.cfg(car_cfg), .raw_idx(raw_idx), .bit_out(c_out));
endmodule

// File: rtl/lut_slice_fu.sv
module lut_slice_fu
  import lut_fu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX_W = $clog2(WIDTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_sel,
  input  logic [TBL_SZ-1:0] cfg_table,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic              carry_in,
  input  logic [AUX_W-1:0]  aux_in,
  output logic [WIDTH-1:0]  fu_res,
  output logic              carry_out
);
  lut_cfg_t [WIDTH-1:0] res_cfg;
  lut_cfg_t [WIDTH-1:0] car_cfg;
  logic     [WIDTH:0]   chain;

  lut_cfg_bank #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .sel(cfg_sel),
    .tbl(cfg_table), .cnt(cfg_count), .res_cfg(res_cfg), .car_cfg(car_cfg)
  );

  assign chain[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_row
    lut_slice u_slice (
      .a_bit(op_a[i]), .b_bit(op_b[i]), .c_in(chain[i]), .aux(aux_in),
      .res_cfg(res_cfg[i]), .car_cfg(car_cfg[i]),
      .r_bit(fu_res[i]), .c_out(chain[i+1])
    );
  end

  assign carry_out = chain[WIDTH];
endmodule

// File: rtl/lut_fu_chk.sv
module lut_fu_chk
  import lut_fu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX_W = $clog2(WIDTH) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [IDX_W-1:0]     cfg_idx,
  input logic [WIDTH-1:0]     op_a,
  input logic [WIDTH-1:0]     op_b,
  input logic                 carry_in,
  input logic [AUX_W-1:0]     aux_in,
  input logic [WIDTH-1:0]     fu_res,
  input logic                 carry_out,
  input lut_cfg_t [WIDTH-1:0] res_cfg
);
  // R1: first sampled cycle after release shows an all-zero output
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fu_res == '0 && carry_out == 1'b0));

  // R2: without an accepted write and with steady inputs the output holds
  assert_no_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $stable(op_a) && $stable(op_b) && $stable(carry_in)
     && $stable(aux_in)) |-> ($stable(fu_res) && $stable(carry_out)));

  // R7: a write aimed past the top slice leaves the output steady
  assert_range_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && $past(cfg_idx) >= IDX_W'(WIDTH) && $stable(op_a)
     && $stable(op_b) && $stable(carry_in) && $stable(aux_in))
    |-> ($stable(fu_res) && $stable(carry_out)));

  // R4: a zero count pins each result bit to entry 0 of its table
  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_cfg[i].cnt == '0) |-> (fu_res[i] == res_cfg[i].tbl[0]));
  end
endmodule

bind lut_slice_fu lut_fu_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .aux_in(aux_in),
  .fu_res(fu_res), .carry_out(carry_out), .res_cfg(res_cfg)
);

// File: tb/lut_slice_fu_bench.sv
module lut_slice_fu_bench;
  localparam int W  = 8;
  localparam int IW = $clog2(W) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic          cfg_sel;
  logic [63:0]   cfg_table;
  logic [2:0]    cfg_count;
  logic [W-1:0]  op_a, op_b;
  logic          carry_in;
  logic [2:0]    aux_in;
  logic [W-1:0]  fu_res;
  logic          carry_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lut_slice_fu #(.WIDTH(W)) u_lut_slice_fu (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_table(cfg_table), .cfg_count(cfg_count),
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .aux_in(aux_in),
    .fu_res(fu_res), .carry_out(carry_out)
  );

  // add vectors: {a, b, cin, expected {cout,sum}}
  localparam logic [25:0] VEC [8] = '{
    {8'h00, 8'h00, 1'b0, 9'h000},
    {8'hFF, 8'h01, 1'b0, 9'h100},
    {8'hFF, 8'h00, 1'b1, 9'h100},
    {8'h7F, 8'h01, 1'b0, 9'h080},
    {8'hAA, 8'h55, 1'b1, 9'h100},
    {8'h12, 8'h34, 1'b1, 9'h047},
    {8'hFF, 8'hFF, 1'b1, 9'h1FF},
    {8'h80, 8'h80, 1'b0, 9'h100}
  };

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic sel, input logic [63:0] t, input logic [2:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_sel = sel; cfg_table = t; cfg_count = c;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic load_all(input logic [63:0] rt, input logic [2:0] rc,
                          input logic [63:0] ct, input logic [2:0] cc);
    for (int i = 0; i < W; i++) begin
      wr(i, 1'b0, rt, rc);
      wr(i, 1'b1, ct, cc);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci, input logic [2:0] x);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci; aux_in = x;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_sel = 1'b0;
    cfg_table = '0; cfg_count = '0;
    op_a = 8'hFF; op_b = 8'hFF; carry_in = 1'b1; aux_in = 3'h7;
    #12;
    check("R1 in reset", {carry_out, fu_res}, 9'h000);
    @(negedge clk); rst_n = 1'b1;
    drive(8'h5A, 8'hC3, 1'b1, 3'h5);
    check("R1 after release", {carry_out, fu_res}, 9'h000);

    // R2: write is not visible before the edge, is after it
    drive(8'h01, 8'h00, 1'b0, 3'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 0; cfg_sel = 1'b0; cfg_table = 64'h96; cfg_count = 3'd3;
    #1 check("R2 before edge", {carry_out, fu_res}, 9'h000);
    @(posedge clk); #1 cfg_we = 1'b0;
    check("R2 after edge", {carry_out, fu_res}, 9'h001);
    // R2: only slice 0 result table was written
    drive(8'h03, 8'h00, 1'b0, 3'h0);
    check("R2 other slices untouched", {carry_out, fu_res}, 9'h001);

    load_all(64'h96, 3'd3, 64'hE8, 3'd3);
    for (int v = 0; v < 8; v++) begin
      drive(VEC[v][25:18], VEC[v][17:10], VEC[v][9], 3'h0);
      check("R8 R5 add vector", {carry_out, fu_res}, VEC[v][8:0]);
    end
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] ra, rb; logic rc;
      ra = W'($urandom); rb = W'($urandom); rc = 1'($urandom);
      drive(ra, rb, rc, 3'($urandom));
      check("R8 add random", {carry_out, fu_res}, {1'b0, ra} + {1'b0, rb} + {8'h00, rc});
    end

    // R6: output follows a second operand change inside one half cycle
    drive(8'h10, 8'h01, 1'b0, 3'h0);
    op_b = 8'h02; #1;
    check("R6 combinational update", {carry_out, fu_res}, 9'h012);

    // R3: xor from index bits 0 and 1, carry table zero
    load_all(64'h6, 3'd2, 64'h0, 3'd0);
    for (int k = 0; k < 15; k++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom); rb = W'($urandom);
      drive(ra, rb, 1'($urandom), 3'($urandom));
      check("R3 xor", {carry_out, fu_res}, {1'b0, ra ^ rb});
    end
    load_all(64'h8, 3'd2, 64'h0, 3'd0);
    for (int k = 0; k < 15; k++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom); rb = W'($urandom);
      drive(ra, rb, 1'($urandom), 3'($urandom));
      check("R3 and", {carry_out, fu_res}, {1'b0, ra & rb});
    end

    // R7: out-of-range slice index changes nothing
    drive(8'hF0, 8'h3C, 1'b0, 3'h0);
    wr(W, 1'b0, {64{1'b1}}, 3'd6);
    wr(W, 1'b1, {64{1'b1}}, 3'd6);
    #1 check("R7 ignored write", {carry_out, fu_res}, 9'h030);

    // R4: masking on slice 0 (other slices keep the and function)
    wr(0, 1'b0, 64'h2, 3'd0);
    drive(8'h01, 8'h00, 1'b0, 3'h0);
    check("R4 count 0 reads entry 0", {8'h00, fu_res[0]}, 9'h000);
    wr(0, 1'b0, 64'h2, 3'd1);
    #1 check("R4 count 1 uses a bit", {8'h00, fu_res[0]}, 9'h001);
    wr(0, 1'b0, 64'h100, 3'd4);
    drive(8'h00, 8'h00, 1'b0, 3'h1);
    check("R4 R3 aux bit 3 active", {8'h00, fu_res[0]}, 9'h001);
    wr(0, 1'b0, 64'h100, 3'd3);
    #1 check("R4 aux bit 3 masked", {8'h00, fu_res[0]}, 9'h000);
    wr(0, 1'b0, 64'h8000_0000_0000_0000, 3'd7);
    drive(8'h01, 8'h01, 1'b1, 3'h7);
    check("R4 count 7 saturates", {8'h00, fu_res[0]}, 9'h001);
    drive(8'h00, 8'h01, 1'b1, 3'h7);
    check("R4 R5 index 62", {8'h00, fu_res[0]}, 9'h000);

    // R5: carry-in reaches slice 0 index bit 2
    wr(0, 1'b0, 64'h10, 3'd3);
    drive(8'h00, 8'h00, 1'b1, 3'h0);
    check("R5 carry_in to slice 0", {8'h00, fu_res[0]}, 9'h001);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule